// File: doc/BRIEF.md
# Dual-Channel PWM Slice With Counter Input Modes

This block is one pulse-width-modulation slice. A 16-bit counter runs between zero and a programmable limit and is compared against two 16-bit thresholds, one per output channel. The rate of the counter is set by a fractional clock divider that works in sixteenths of a clock. The counter can wrap to zero at the limit (edge-aligned) or reverse and count back down (centre-aligned). Each channel has its own output polarity control.

The second channel can be turned around into an input. The input then either gates the divided count or supplies the count itself, one step per rising or per falling edge. This lets the slice measure duty cycle or frequency. Single-count phase nudges shift the waveform forward or back by one count without rewriting the counter. The limit and both thresholds are double-buffered. Software writes a pending copy, and the copy that is actually used changes only at a period boundary, or at once while the slice is stopped.

Configuration goes through a simple write port: an address, a 16-bit data word and a write strobe. The counter value is always visible on a read-back port.

Top module: `pwm_slice`

## Requirements
- R1: After reset the counter is 0, the limit is 0xFFFF, both thresholds are 0, the divider is 1.0, the slice is stopped, free-running edge-aligned mode is selected, neither channel is inverted, both outputs are low and the B output enable is high.
- R2: A write with address 0 sets the control word: bit 0 run, bit 1 centre-aligned, bit 2 invert A, bit 3 invert B, bits 5:4 mode (0 free-running, 1 gated, 2 rising-edge, 3 falling-edge). Address 1 sets the divider (bits 11:4 integer, bits 3:0 sixteenths). Address 2 sets the limit, 3 threshold A, 4 threshold B. Address 5 loads the counter directly in the cycle after the write, and this takes priority over counting.
- R3: In edge-aligned mode the counter steps from the limit to 0 and otherwise adds one per count event. The counter holds its value while the slice is stopped.
- R4: In centre-aligned mode the counter climbs to the limit and then falls back to 0, repeating with a period of twice the limit.
- R5: Before inversion, a channel output is high exactly while the counter is below that channel's threshold. A threshold above the limit gives a constant high.
- R6: The invert bit of a channel flips only that channel's output level.
- R7: In free-running mode one count event occurs per divided tick. The divider value D (in sixteenths) yields on average 16 ticks per D clocks, as a phase accumulator starting from 0. Values below 1.0 act as 1.0, so 1.0 gives one tick per clock.
- R8: In gated mode, divided ticks count only while the synchronised B input is high. The B input passes two flops, so a high level of N cycles gives N counts.
- R9: In rising-edge mode each rising edge on the B input adds exactly one count, and in falling-edge mode each falling edge adds one. An edge of the opposite sense adds nothing.
- R10: The B output enable is high only in free-running mode.
- R11: While the divider exceeds 1.0, an advance pulse inserts one extra count on a cycle with no count event, and a retard pulse suppresses the next count event. With the divider at 1.0 both pulses are ignored.
- R12: Limit and threshold writes made while the slice runs take effect only at the edge-aligned wrap, or at the lower turning point in centre-aligned mode. While the slice is stopped they take effect on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_addr | input | 3 | Configuration register address |
| wr_data | input | 16 | Configuration write data |
| adv_i | input | 1 | One-cycle phase advance request |
| ret_i | input | 1 | One-cycle phase retard request |
| b_in | input | 1 | Channel B input level (asynchronous) |
| out_a | output | 1 | Channel A PWM output |
| out_b | output | 1 | Channel B PWM output |
| out_b_oe | output | 1 | Channel B output enable (high in free-running mode) |
| ctr_o | output | 16 | Current counter value |

## Verification
A configuration write is registered at the clock edge after it is driven. Run-enable takes effect there, so the first divided count arrives one edge later. The outputs follow the counter combinationally, within the same cycle. The B input needs two synchroniser edges before gating or edge detection sees it, so the count it causes lands on the third edge. The bench drives every input on the falling edge and samples on the falling edge. Counter expectations are indexed by the number of rising edges since the enabling write. Phase nudges and input-mode results are checked after a settle window longer than these delays.

// File: rtl/pwm_slice_pkg.sv
package pwm_slice_pkg;
  typedef enum logic [1:0] {
    MODE_FREE  = 2'd0,
    MODE_GATED = 2'd1,
    MODE_RISE  = 2'd2,
    MODE_FALL  = 2'd3
  } cnt_mode_e;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_DIV  = 3'd1;
  localparam logic [2:0] ADDR_TOP  = 3'd2;
  localparam logic [2:0] ADDR_CCA  = 3'd3;
  localparam logic [2:0] ADDR_CCB  = 3'd4;
  localparam logic [2:0] ADDR_CTR  = 3'd5;
endpackage

// File: rtl/pwm_clkdiv.sv
module pwm_clkdiv #(
  parameter int DIW = 8,
  parameter int DFW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [DIW+DFW-1:0] div_i,
  output logic               tick
);
  localparam int DW = DIW + DFW;
  localparam logic [DW:0] ONE = (DW+1)'(1) << DFW;

  logic [DW:0] acc_q, acc_d, sum, div_eff;

  always_comb begin
    div_eff = ({1'b0, div_i} < ONE) ? ONE : {1'b0, div_i};
    sum     = acc_q + ONE;
    tick    = run && (sum >= div_eff);
    if (!run)      acc_d = '0;
    else if (tick) acc_d = sum - div_eff;
    else           acc_d = sum;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;

  // R7
  tick_full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ({1'b0, div_i} <= ONE)) |-> tick);
endmodule

// File: rtl/pwm_insync.sv
module pwm_insync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end

  assign level = s2_q;
  assign rise  = s2_q & ~s3_q;
  assign fall  = ~s2_q & s3_q;

  // R9
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          pc,
  input  logic          step,
  input  logic          ld_ctr,
  input  logic [CW-1:0] ctr_val,
  input  logic [CW-1:0] top_nxt,
  input  logic [CW-1:0] cca_nxt,
  input  logic [CW-1:0] ccb_nxt,
  output logic [CW-1:0] ctr,
  output logic          cmp_a,
  output logic          cmp_b
);
  logic [CW-1:0] ctr_q, ctr_d, top_q, cca_q, ccb_q, nxt;
  logic          up_q, up_d, load_pt;

  always_comb begin
    load_pt = 1'b0;
    nxt     = ctr_q;
    up_d    = up_q;
    if (!pc) begin
      up_d = 1'b1;
      if (ctr_q >= top_q) begin
        nxt     = '0;
        load_pt = step;
      end else begin
        nxt = ctr_q + 1'b1;
      end
    end else if (up_q) begin
      if (ctr_q >= top_q) begin
        nxt  = (top_q == '0) ? '0 : ctr_q - 1'b1;
        up_d = (top_q == '0);
      end else begin
        nxt = ctr_q + 1'b1;
      end
    end else begin
      if (ctr_q == '0) begin
        nxt     = (top_nxt == '0) ? '0 : CW'(1);
        up_d    = 1'b1;
        load_pt = step;
      end else begin
        nxt = ctr_q - 1'b1;
      end
    end
    if (ld_ctr)    ctr_d = ctr_val;
    else if (step) ctr_d = nxt;
    else           ctr_d = ctr_q;
    if (ld_ctr)     up_d = 1'b1;
    else if (!step) up_d = up_q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctr_q <= '0;
      up_q  <= 1'b1;
    end else begin
      ctr_q <= ctr_d;
      up_q  <= up_d;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      top_q <= '1;
      cca_q <= '0;
      ccb_q <= '0;
    end else if (!en || load_pt) begin
      top_q <= top_nxt;
      cca_q <= cca_nxt;
      ccb_q <= ccb_nxt;
    end

  assign ctr   = ctr_q;
  assign cmp_a = ctr_q < cca_q;
  assign cmp_b = ctr_q < ccb_q;

  // R3
  ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ctr |=> (ctr_q == $past(ctr_q) || ctr_q == $past(ctr_q) + 1'b1 ||
                 ctr_q == $past(ctr_q) - 1'b1 || ctr_q == '0));
  // R3
  ctr_hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ld_ctr) |=> $stable(ctr_q));
  // R5
  cmp_above_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cca_q > top_q && ctr_q <= top_q) |-> cmp_a);
  // R12
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !step) |=> $stable(top_q));
endmodule

// File: rtl/pwm_slice.sv
module pwm_slice
  import pwm_slice_pkg::*;
#(
  parameter int CW  = 16,
  parameter int DIW = 8,
  parameter int DFW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          adv_i,
  input  logic          ret_i,
  input  logic          b_in,
  output logic          out_a,
  output logic          out_b,
  output logic          out_b_oe,
  output logic [CW-1:0] ctr_o
);
  localparam int DW = DIW + DFW;
  localparam logic [DW-1:0] DIV_ONE = DW'(1) << DFW;

  logic          en_q, pc_q, inv_a_q, inv_b_q;
  cnt_mode_e     mode_q;
  logic [DW-1:0] div_q;
  logic [CW-1:0] top_q, cca_q, ccb_q;
  logic          adv_q, ret_q, adv_d, ret_d;
  logic          tick, lvl, rise, fall, src, slow, step, adv_now, ld_ctr;
  logic          cmp_a, cmp_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q <= 1'b0; pc_q <= 1'b0; inv_a_q <= 1'b0; inv_b_q <= 1'b0;
      mode_q <= MODE_FREE;
      div_q  <= DIV_ONE;
      top_q  <= '1; cca_q <= '0; ccb_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL: begin
          en_q    <= wr_data[0];
          pc_q    <= wr_data[1];
          inv_a_q <= wr_data[2];
          inv_b_q <= wr_data[3];
          mode_q  <= cnt_mode_e'(wr_data[5:4]);
        end
        ADDR_DIV: div_q <= wr_data[DW-1:0];
        ADDR_TOP: top_q <= wr_data;
        ADDR_CCA: cca_q <= wr_data;
        ADDR_CCB: ccb_q <= wr_data;
        default:  ;
      endcase
    end

  assign ld_ctr = wr_en && (wr_addr == ADDR_CTR);

  pwm_clkdiv #(.DIW(DIW), .DFW(DFW)) u_div (
    .clk(clk), .rst_n(rst_n), .run(en_q), .div_i(div_q), .tick(tick));

  pwm_insync u_sync (
    .clk(clk), .rst_n(rst_n), .pin(b_in), .level(lvl), .rise(rise), .fall(fall));

  always_comb begin
    case (mode_q)
      MODE_GATED: src = tick & lvl;
      MODE_RISE:  src = rise;
      MODE_FALL:  src = fall;
      default:    src = tick;
    endcase
    src     = src & en_q;
    slow    = div_q > DIV_ONE;
    adv_now = en_q && adv_q && !src;
    step    = (src && !ret_q) || adv_now;
    if (!en_q)              adv_d = 1'b0;
    else if (adv_i && slow) adv_d = 1'b1;
    else if (adv_now)       adv_d = 1'b0;
    else                    adv_d = adv_q;
    if (!en_q)              ret_d = 1'b0;
    else if (ret_i && slow) ret_d = 1'b1;
    else if (src)           ret_d = 1'b0;
    else                    ret_d = ret_q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      adv_q <= 1'b0;
      ret_q <= 1'b0;
    end else begin
      adv_q <= adv_d;
      ret_q <= ret_d;
    end

  pwm_counter #(.CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .en(en_q), .pc(pc_q), .step(step),
    .ld_ctr(ld_ctr), .ctr_val(wr_data), .top_nxt(top_q), .cca_nxt(cca_q),
    .ccb_nxt(ccb_q), .ctr(ctr_o), .cmp_a(cmp_a), .cmp_b(cmp_b));

  assign out_a    = cmp_a ^ inv_a_q;
  assign out_b    = cmp_b ^ inv_b_q;
  assign out_b_oe = (mode_q == MODE_FREE);

  // R11
  nudge_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slow && !adv_q) |=> !adv_q);
  // R10
  b_oe_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_GATED || mode_q == MODE_RISE || mode_q == MODE_FALL) |-> !out_b_oe);
endmodule

// File: tb/pwm_slice_tb.sv
module pwm_slice_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [15:0] wr_data = 16'd0;
  logic        adv_i = 1'b0, ret_i = 1'b0, b_in = 1'b0;
  logic        out_a, out_b, out_b_oe;
  logic [15:0] ctr_o;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  pwm_slice u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .adv_i(adv_i), .ret_i(ret_i), .b_in(b_in),
    .out_a(out_a), .out_b(out_b), .out_b_oe(out_b_oe), .ctr_o(ctr_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // stop, program, clear counter, then start with ctrl word (returns at sample k=0)
  task automatic setup(input logic [15:0] top, input logic [15:0] ca, input logic [15:0] cb,
                       input logic [15:0] dv, input logic [15:0] ctrl);
    wr(3'd0, 16'h0000);
    wr(3'd2, top); wr(3'd3, ca); wr(3'd4, cb); wr(3'd1, dv);
    wr(3'd5, 16'h0000);
    wait_n(2);
    wr(3'd0, ctrl);
  endtask

  task automatic t_reset;
    chk(ctr_o == 16'd0, "R1 ctr", ctr_o, 0);
    chk(out_a == 1'b0 && out_b == 1'b0, "R1 outs", {out_a, out_b}, 0);
    chk(out_b_oe == 1'b1, "R1 oe", out_b_oe, 1);
  endtask

  task automatic t_free;
    bit ok_c = 1, ok_a = 1, ok_b = 1;
    int bad = 0;
    setup(16'd4, 16'd2, 16'd5, 16'h010, 16'h0001);
    for (int k = 0; k < 12; k++) begin
      if (ctr_o != 16'(k % 5)) begin ok_c = 0; bad = ctr_o; end
      if (out_a != ((k % 5) < 2)) ok_a = 0;
      if (out_b != 1'b1) ok_b = 0;
      @(negedge clk);
    end
    chk(ok_c, "R3 edge-aligned wrap", bad, 0);
    chk(ok_a, "R5 compare A", out_a, 0);
    chk(ok_b, "R5 threshold above limit", out_b, 1);
    wr(3'd0, 16'h0005);
    ok_a = 1;
    for (int k = 0; k < 6; k++) begin
      if (out_a != !(ctr_o < 2)) ok_a = 0;
      if (out_b != 1'b1) ok_b = 0;
      @(negedge clk);
    end
    chk(ok_a, "R6 invert A", out_a, 0);
    chk(ok_b, "R6 B unaffected", out_b, 1);
    wr(3'd5, 16'h1234);
    chk(ctr_o == 16'h1234, "R2 counter load", ctr_o, 16'h1234);
    wr(3'd0, 16'h0000);
    begin
      logic [15:0] held = ctr_o;
      wait_n(5);
      chk(ctr_o == held, "R3 hold when stopped", ctr_o, held);
    end
  endtask

  task automatic t_pc;
    bit ok = 1;
    int bad = 0;
    setup(16'd3, 16'd2, 16'd0, 16'h010, 16'h0003);
    for (int k = 0; k < 14; k++) begin
      int m = k % 6;
      int e = (m <= 3) ? m : 6 - m;
      if (ctr_o != 16'(e)) begin ok = 0; bad = ctr_o; end
      @(negedge clk);
    end
    chk(ok, "R4 centre-aligned", bad, 0);
  endtask

  task automatic t_div;
    bit ok = 1;
    int bad = 0;
    setup(16'hFFFF, 16'd0, 16'd0, 16'h020, 16'h0001);
    for (int k = 0; k < 10; k++) begin
      if (ctr_o != 16'(k / 2)) begin ok = 0; bad = ctr_o; end
      @(negedge clk);
    end
    chk(ok, "R7 divide 2.0", bad, 0);
    ok = 1;
    setup(16'hFFFF, 16'd0, 16'd0, 16'h018, 16'h0001);
    for (int k = 0; k < 12; k++) begin
      if (ctr_o != 16'((2 * k) / 3)) begin ok = 0; bad = ctr_o; end
      @(negedge clk);
    end
    chk(ok, "R7 divide 1.5", bad, 0);
    ok = 1;
    setup(16'hFFFF, 16'd0, 16'd0, 16'h008, 16'h0001);
    for (int k = 0; k < 8; k++) begin
      if (ctr_o != 16'(k)) begin ok = 0; bad = ctr_o; end
      @(negedge clk);
    end
    chk(ok, "R7 below 1.0 clamps", bad, 0);
  endtask

  task automatic t_nudge;
    setup(16'hFFFF, 16'd0, 16'd0, 16'h020, 16'h0001);
    wait_n(4);
    adv_i = 1'b1; @(negedge clk); adv_i = 1'b0;
    wait_n(5);
    chk(ctr_o == 16'd6, "R11 advance", ctr_o, 6);
    ret_i = 1'b1; @(negedge clk); ret_i = 1'b0;
    wait_n(3);
    chk(ctr_o == 16'd7, "R11 retard", ctr_o, 7);
    setup(16'hFFFF, 16'd0, 16'd0, 16'h010, 16'h0001);
    wait_n(2);
    adv_i = 1'b1; ret_i = 1'b1; @(negedge clk); adv_i = 1'b0; ret_i = 1'b0;
    wait_n(7);
    chk(ctr_o == 16'd10, "R11 ignored at 1.0", ctr_o, 10);
  endtask

  task automatic t_shadow;
    bit ok = 1;
    int bad = 0;
    setup(16'd9, 16'd0, 16'd0, 16'h010, 16'h0001);
    wait_n(3);
    wr(3'd2, 16'd3);
    for (int k = 4; k < 18; k++) begin
      int e = (k <= 9) ? k : (k - 10) % 4;
      if (ctr_o != 16'(e)) begin ok = 0; bad = ctr_o; end
      @(negedge clk);
    end
    chk(ok, "R12 limit deferred to wrap", bad, 0);
  endtask

  task automatic t_inputs;
    setup(16'hFFFF, 16'd0, 16'd0, 16'h010, 16'h0011);
    chk(out_b_oe == 1'b0, "R10 oe in gated", out_b_oe, 0);
    wait_n(5);
    chk(ctr_o == 16'd0, "R8 gated low", ctr_o, 0);
    b_in = 1'b1; wait_n(6); b_in = 1'b0; wait_n(5);
    chk(ctr_o == 16'd6, "R8 gated count", ctr_o, 6);
    setup(16'hFFFF, 16'd0, 16'd0, 16'h010, 16'h0021);
    for (int p = 0; p < 3; p++) begin
      b_in = 1'b1; wait_n(3); b_in = 1'b0; wait_n(3);
    end
    wait_n(3);
    chk(ctr_o == 16'd3, "R9 rising edges", ctr_o, 3);
    setup(16'hFFFF, 16'd0, 16'd0, 16'h010, 16'h0031);
    b_in = 1'b1; wait_n(6);
    chk(ctr_o == 16'd0, "R9 falling ignores rise", ctr_o, 0);
    b_in = 1'b0; wait_n(4);
    chk(ctr_o == 16'd1, "R9 falling edge", ctr_o, 1);
    wr(3'd0, 16'h0001);
    chk(out_b_oe == 1'b1, "R10 oe in free", out_b_oe, 1);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    t_reset;
    t_free;
    t_pc;
    t_div;
    t_nudge;
    t_shadow;
    t_inputs;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule